// File: doc/BRIEF.md
# Dual-Edge Capture Interval Timer

An 8-bit up-counter driven from a selectable fraction of the system clock. It has two modes. In capture mode it timestamps both edges of an external signal. The counter value at a rising edge goes into one holding register, and the value at a falling edge goes into another. A selected edge can also restart the count from zero, so the block can measure high time, low time or period directly. In interval mode the counter runs freely and reports each wrap-around.

Software uses a small register port with one shared address. It reads the counter and both capture registers, programs a control register, and clears sticky flags by writing zeros. A single interrupt line reports either a chosen capture edge or an overflow. An overflow is recorded in one of two flags, depending on the level of the capture signal when it occurs.

Top module: `dual_edge_timer`

## Requirements
- R1: After reset, the control register (address 0), status (address 1), counter (address 2), rise capture (address 3) and fall capture (address 4) all read 0, and `irq` is low.
- R2: The counter advances by one on each prescaler tick. Control bits [1:0] select the tick period: 00 = 64 clocks, 01 = 32, 10 = 8, 11 = 2, counted from a free-running 6-bit divider that starts at reset.
- R3: The counter wraps from 0xFF to 0x00. A wrap that occurs while the capture level is low sets status bit 0 (overflow-low).
- R4: A wrap that occurs while the capture level is high sets status bit 1 (overflow-high).
- R5: The capture level is `cap_in` after a two-flop synchronizer, ANDed with `cap_mode`. Its edges act two clocks after `cap_in` is sampled. On a rising edge the counter is copied to address 3, and on a falling edge it is copied to address 4.
- R6: Control bits [3:2] select counter clearing: 00 = never, 01 = on rising edges, 10 = on falling edges, 11 = on both. On such an edge the value captured is the count before clearing, and the counter is 0 in the next cycle.
- R7: Status bit 2 (timer flag) is set by the edge chosen with control bit 4 (1 = rising, 0 = falling). It is also set by any wrap when control bit 5 (overflow interrupt enable) is 1.
- R8: `irq` is high exactly when status bit 2 and control bit 6 (interrupt enable) are both 1.
- R9: Writing address 1 clears each status bit whose data bit is 0 and leaves bits written 1 unchanged. A flag event in the same cycle wins over the clear.
- R10: Changing `cap_mode` while the synchronized input is high changes the capture level, so the change acts as an edge. Entering capture mode gives a rising edge, and leaving it gives a falling edge, with capture, clear and flag effects.
- R11: While `cap_mode` stays 0, `cap_in` activity changes neither capture register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_mode | input | 1 | 1 = capture mode, 0 = interval mode |
| cap_in | input | 1 | Asynchronous signal to be timed |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for read and write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the addressed register |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situations to reach are the coincidences: an overflow that lands in the same cycle as a clearing edge, or a flag set in the same cycle as a software clear. Both depend on the prescaler phase and the synchronizer latency. The stimulus uses the fastest tick period and toggles the input at many offsets over long runs. A per-clock reference model flags any cycle where one of these collisions resolves wrongly. Mode-change edges are reached by holding the input high while switching `cap_mode` both ways.

// File: rtl/dual_edge_timer.sv
module dual_edge_timer #(
  parameter int W  = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_mode,
  input  logic          cap_in,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wr_data,
  output logic [W-1:0]  rd_data,
  output logic          irq
);
  localparam int DIVW = 6;

  logic            s1, s2, lvl_q;
  logic [DIVW-1:0] div_q;
  logic [6:0]      ctrl_q;
  logic            ovf_lo, ovf_hi, tflag;
  logic [W-1:0]    cnt_q, cap_rise_q, cap_fall_q;
  logic            tick;

  wire [1:0] clk_sel  = ctrl_q[1:0];
  wire [1:0] clr_sel  = ctrl_q[3:2];
  wire       edge_sel = ctrl_q[4];
  wire       ovf_ie   = ctrl_q[5];
  wire       irq_en   = ctrl_q[6];

  wire lvl   = cap_mode & s2;
  wire rise  = lvl & ~lvl_q;
  wire fall  = ~lvl & lvl_q;
  wire clr   = (rise & clr_sel[0]) | (fall & clr_sel[1]);
  wire ovf   = tick & (&cnt_q) & ~clr;
  wire wr_ct = wr_en && addr == AW'(0);
  wire wr_st = wr_en && addr == AW'(1);
  wire ev_fl = (edge_sel ? rise : fall) | (ovf & ovf_ie);

  always_comb begin
    case (clk_sel)
      2'd0:    tick = &div_q;
      2'd1:    tick = &div_q[4:0];
      2'd2:    tick = &div_q[2:0];
      default: tick = div_q[0];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      lvl_q <= 1'b0;
      div_q <= '0;
    end else begin
      s1 <= cap_in;
      s2 <= s1;
      lvl_q <= lvl;
      div_q <= div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cap_rise_q <= '0;
      cap_fall_q <= '0;
    end else begin
      if (clr)       cnt_q <= '0;
      else if (tick) cnt_q <= cnt_q + 1'b1;
      if (rise) cap_rise_q <= cnt_q;
      if (fall) cap_fall_q <= cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ovf_lo <= 1'b0;
      ovf_hi <= 1'b0;
      tflag  <= 1'b0;
    end else begin
      if (wr_ct) ctrl_q <= wr_data[6:0];
      ovf_lo <= (ovf & ~lvl) | (ovf_lo & ~(wr_st & ~wr_data[0]));
      ovf_hi <= (ovf & lvl)  | (ovf_hi & ~(wr_st & ~wr_data[1]));
      tflag  <= ev_fl        | (tflag  & ~(wr_st & ~wr_data[2]));
    end
  end

  always_comb begin
    case (addr)
      AW'(0):  rd_data = W'({1'b0, ctrl_q});
      AW'(1):  rd_data = W'({tflag, ovf_hi, ovf_lo});
      AW'(2):  rd_data = cnt_q;
      AW'(3):  rd_data = cap_rise_q;
      AW'(4):  rd_data = cap_fall_q;
      default: rd_data = '0;
    endcase
  end

  assign irq = tflag & irq_en;
endmodule

// File: rtl/dual_edge_timer_chk.sv
module dual_edge_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cap_mode,
  input logic [7:0] cnt,
  input logic [7:0] cap_rise,
  input logic [7:0] cap_fall,
  input logic       ovf_lo,
  input logic       ovf_hi
);
  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt) |-> (cnt == 8'd0 || cnt == 8'($past(cnt) + 8'd1)));

  p_wrap_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_lo) |-> $past(cnt) == 8'hFF);

  p_wrap_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_hi) |-> $past(cnt) == 8'hFF);

  p_rise_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cap_rise) |-> cap_rise == $past(cnt));

  p_fall_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cap_fall) |-> cap_fall == $past(cnt));

  p_interval_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_mode && $past(!cap_mode)) |=> ($stable(cap_rise) && $stable(cap_fall)));
endmodule

bind dual_edge_timer dual_edge_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cap_mode(cap_mode), .cnt(cnt_q),
  .cap_rise(cap_rise_q), .cap_fall(cap_fall_q), .ovf_lo(ovf_lo), .ovf_hi(ovf_hi)
);

// File: tb/dual_edge_timer_test.sv
module dual_edge_timer_test;
  logic clk = 1'b0, rst_n = 1'b0, cap_mode = 1'b0, cap_in = 1'b0, wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic irq;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  dual_edge_timer uut (.clk(clk), .rst_n(rst_n), .cap_mode(cap_mode), .cap_in(cap_in),
    .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq(irq));

  always #4 clk = ~clk;

  // behavioural reference model
  int m_ctrl, m_lo, m_hi, m_fl, m_cnt, m_rise, m_fall, m_div, m_prev;
  bit sq[$];

  function automatic int m_rd(int a);
    case (a)
      0: return m_ctrl;
      1: return m_lo + 2 * m_hi + 4 * m_fl;
      2: return m_cnt;
      3: return m_rise;
      4: return m_fall;
      default: return 0;
    endcase
  endfunction

  task automatic chk(int act, int exp, string tag);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_lo = 0; m_hi = 0; m_fl = 0; m_cnt = 0;
      m_rise = 0; m_fall = 0; m_div = 0; m_prev = 0;
      sq = '{0, 0};
    end else begin
      int per, sel, lvl, rise, fall, tick, clr, ovf;
      sel  = m_ctrl % 4;
      per  = (sel == 0) ? 64 : (sel == 1) ? 32 : (sel == 2) ? 8 : 2;
      lvl  = (cap_mode && sq[0]) ? 1 : 0;
      rise = (lvl == 1 && m_prev == 0) ? 1 : 0;
      fall = (lvl == 0 && m_prev == 1) ? 1 : 0;
      tick = (m_div % per == per - 1) ? 1 : 0;
      clr  = ((rise == 1 && ((m_ctrl >> 2) & 1) == 1) || (fall == 1 && ((m_ctrl >> 3) & 1) == 1)) ? 1 : 0;
      ovf  = (tick == 1 && m_cnt == 255 && clr == 0) ? 1 : 0;
      if (rise == 1) m_rise = m_cnt;
      if (fall == 1) m_fall = m_cnt;
      if (clr == 1) m_cnt = 0;
      else if (tick == 1) m_cnt = (m_cnt + 1) % 256;
      if (wr_en && addr == 3'd1) begin
        if (!wr_data[0]) m_lo = 0;
        if (!wr_data[1]) m_hi = 0;
        if (!wr_data[2]) m_fl = 0;
      end
      if (ovf == 1 && lvl == 0) m_lo = 1;
      if (ovf == 1 && lvl == 1) m_hi = 1;
      if (((m_ctrl >> 4) & 1) == 1 ? rise == 1 : fall == 1) m_fl = 1;
      if (ovf == 1 && ((m_ctrl >> 5) & 1) == 1) m_fl = 1;
      if (wr_en && addr == 3'd0) m_ctrl = wr_data % 128;
      m_div = (m_div + 1) % 64;
      m_prev = lvl;
      void'(sq.pop_front());
      sq.push_back(cap_in);
      #2;
      if (!done) begin
        chk(rd_data, m_rd(addr), (addr == 3 || addr == 4) ? "R5" : (addr == 1) ? "R3" : "R2");
        chk(irq, m_fl * ((m_ctrl >> 6) & 1), "R8");
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); wr_en = 1; addr = 3'(a); wr_data = 8'(d);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(int a, output int v);
    @(negedge clk); addr = 3'(a); #1 v = rd_data;
  endtask

  task automatic edge_in(bit v);
    @(negedge clk); cap_in = v; idle(4);
  endtask

  initial begin
    int v, r0, f0;
    idle(4);
    rst_n = 1;
    for (int a = 0; a < 5; a++) begin rd(a, v); chk(v, 0, "R1"); end
    chk(irq, 0, "R1");

    idle(200);
    rd(2, v); chk(v, m_cnt, "R2 div64");
    chk((v >= 2 && v <= 4) ? 1 : 0, 1, "R2 div64 range");
    wr(0, 8'h02); idle(100);
    rd(2, v); chk(v, m_cnt, "R2 div8");
    wr(0, 8'h03); idle(600);
    rd(1, v); chk(v & 1, 1, "R3 interval wrap sets overflow-low");
    chk(v & 2, 0, "R4 no overflow-high while low");
    wr(1, 8'h07); rd(1, v); chk(v & 1, 1, "R9 write one keeps flag");
    wr(1, 8'h00); rd(1, v); chk(v, 0, "R9 write zero clears");

    cap_mode = 1;
    edge_in(1); rd(3, v); chk(v, m_rise, "R5 rise capture");
    edge_in(0); rd(4, v); chk(v, m_fall, "R5 fall capture");
    chk((m_rise != m_fall) ? 1 : 0, 1, "R5 distinct stamps");
    edge_in(1); idle(600);
    rd(1, v); chk(v & 2, 2, "R4 overflow-high while input high");
    wr(1, 8'h00);

    wr(0, 8'h07); edge_in(0); edge_in(1);
    rd(2, v); chk((v < 4) ? 1 : 0, 1, "R6 cleared on rise");
    rd(3, v); chk(v, m_rise, "R6 pre-clear capture");
    wr(0, 8'h0B); idle(37); edge_in(0);
    rd(2, v); chk((v < 4) ? 1 : 0, 1, "R6 cleared on fall");
    wr(0, 8'h0F); for (int k = 0; k < 6; k++) begin idle(k * 7 + 3); edge_in(k % 2 == 0); end
    rd(2, v); chk(v, m_cnt, "R6 both edges");
    for (int k = 0; k < 40; k++) begin idle(k % 9); edge_in(k % 2 == 1); end
    rd(1, v); chk(v, m_rd(1), "R6 clear versus overflow coincidence");

    wr(0, 8'h13); wr(1, 8'h00); edge_in(0); edge_in(1);
    rd(1, v); chk(v & 4, 4, "R7 rising edge flag");
    wr(1, 8'h00); edge_in(0);
    rd(1, v); chk(v & 4, 0, "R7 falling edge ignored when rise selected");
    wr(0, 8'h23); wr(1, 8'h00); idle(600);
    rd(1, v); chk(v & 4, 4, "R7 overflow sets flag");
    chk(irq, 0, "R8 irq masked");
    wr(0, 8'h63); rd(1, v); chk(irq, 1, "R8 irq asserted");
    wr(1, 8'h03); rd(1, v); chk(v & 4, 0, "R9 timer flag cleared");
    chk(irq, 0, "R8 irq follows flag");

    wr(0, 8'h13); cap_mode = 0; edge_in(1); wr(1, 8'h00);
    @(negedge clk); cap_mode = 1; idle(3);
    rd(1, v); chk(v & 4, 4, "R10 mode entry acts as rise");
    rd(3, v); chk(v, m_rise, "R10 mode entry capture");
    @(negedge clk); cap_mode = 0; idle(3);
    rd(4, v); chk(v, m_fall, "R10 mode exit capture");

    rd(3, r0); rd(4, f0);
    for (int k = 0; k < 10; k++) begin idle(k + 1); edge_in(k % 2 == 0); end
    rd(3, v); chk(v, r0, "R11 rise reg unchanged");
    rd(4, v); chk(v, f0, "R11 fall reg unchanged");

    wr(0, 8'h01); cap_mode = 1;
    for (int k = 0; k < 60; k++) begin idle(k % 13 + 1); edge_in(k % 3 != 0); end
    idle(10);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule